// File: doc/BRIEF.md
# GPIO Input Qualification Filter

This block conditions a bank of general-purpose input pins before the rest of the chip uses them. Each pin has a two-bit mode that chooses one of four treatments. The input can be synchronized with two flops, or it can be synchronized and then filtered so that a new level is accepted only after three or six consecutive samples agree. The fourth mode passes the raw pad level straight through. Filtering samples the synchronized input on a strobe. One prescale counter makes that strobe for the whole bank, and its spacing comes from a separate period input.

All the mode bits sit in one 32-bit select register. Pin i uses bits 2i+1:2i. Software writes the register only while the protect-release input is high, and the upper half always reads as zero. Each pin also has a configuration input that says whether the pin serves a peripheral or plain GPIO. The raw bypass is honoured only for peripheral pins. A GPIO pin in bypass mode behaves like a plain synchronized pin.

Top module: `gpio_qual_bank`

## Requirements
- R1: While reset is high and one clock edge later, the select register reads 0 and every filtered output is 0 (with inputs held at 0).
- R2: Mode 00 (bits 2i+1:2i = 2'b00): a change on pin_raw[i] appears on pin_out[i] after exactly three rising clock edges.
- R3: Mode 01: pin_out[i] takes a new level only on a sample strobe at which the current sample and the two before it all show that level. Otherwise it holds.
- R4: Mode 10: the same as R3, but six consecutive agreeing samples are needed.
- R5: With period 0 the sample strobe fires every clock. With period n>0 it fires once every 2n clocks, the first time 2n clocks after reset.
- R6: Mode 11 with pin_periph[i]=1: pin_out[i] equals pin_raw[i] in the same cycle, with no register in the path.
- R7: Mode 11 with pin_periph[i]=0: the pin behaves exactly as in mode 00.
- R8: A write (wr_en=1) while unlock=0 leaves the select register unchanged.
- R9: rd_data[31:16] reads 0 whatever was written. Only wr_data[15:0] is stored.
- R10: Pin i's mode is taken from select bits 2i+1:2i, and rd_data returns the stored value on the next cycle after an accepted write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the select register |
| unlock | input | 1 | Protect release; writes land only while high |
| wr_data | input | 32 | Write data for the select register |
| rd_data | output | 32 | Select register read value |
| period | input | 8 | Sample spacing: 0 = every clock, n = every 2n clocks |
| pin_periph | input | 8 | Per pin: 1 = peripheral function, 0 = GPIO |
| pin_raw | input | 8 | Unconditioned pad inputs |
| pin_out | output | 8 | Conditioned pin levels |

## Verification
The bench targets glitches that are one or two samples shorter than the filter length, and mode or period changes in the middle of a run. A filter with an off-by-one would let such a glitch through or would lag by a strobe. A prescaler that divided by n instead of 2n would sample too often, and the filtered edges would arrive early. The bench checks that bypass applies only to peripheral-configured pins and only in mode 11. It also checks that writes made while locked are dropped and that the reserved half reads zero. A design that got these wrong would show raw glitches on GPIO pins, would accept changes while protected, or would echo the reserved bits.

// File: rtl/gqf_pkg.sv
package gqf_pkg;
  typedef enum logic [1:0] {
    M_SYNC  = 2'b00,
    M_QUAL3 = 2'b01,
    M_QUAL6 = 2'b10,
    M_RAW   = 2'b11
  } gqf_mode_e;
endpackage

// File: rtl/gqf_sel_reg.sv
module gqf_sel_reg #(
  parameter int DATA_W = 32,
  parameter int NPINS  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              unlock,
  input  logic [DATA_W-1:0] wr_data,
  output logic [2*NPINS-1:0] sel,
  output logic [DATA_W-1:0] rd_data
);
  localparam int SEL_W = 2 * NPINS;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= '0;
    end else if (wr_en && unlock) begin
      sel <= wr_data[SEL_W-1:0];
    end
  end

  assign rd_data = {{(DATA_W-SEL_W){1'b0}}, sel};

  p_locked_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && unlock)) |=> $stable(sel));
endmodule

// File: rtl/gqf_strobe.sv
module gqf_strobe #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] period,
  output logic             strobe
);
  localparam int CNT_W = PER_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit  = {period, 1'b0} - CNT_W'(1);
  assign strobe = (period == '0) || (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (strobe) cnt <= '0;
    else             cnt <= cnt + CNT_W'(1);
  end

  p_no_back_to_back_r5: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (!strobe || period == '0));
endmodule

// File: rtl/gqf_pin.sv
module gqf_pin
  import gqf_pkg::*;
#(
  parameter int SHORT_N = 3,
  parameter int LONG_N  = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       raw,
  input  logic [1:0] mode,
  input  logic       periph,
  input  logic       strobe,
  output logic       pout
);
  localparam int HIST_W = LONG_N - 1;

  logic              s1, s2;
  logic [HIST_W-1:0] hist;
  logic              filt;
  logic              agree_short, agree_long;
  logic              bypass;

  assign agree_short = (hist[SHORT_N-2:0] == {(SHORT_N-1){s2}});
  assign agree_long  = (hist[LONG_N-2:0]  == {(LONG_N-1){s2}});
  assign bypass      = (mode == M_RAW) && periph;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      hist <= '0;
      filt <= 1'b0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (strobe) hist <= {hist[HIST_W-2:0], s2};
      case (mode)
        M_QUAL3: if (strobe && agree_short) filt <= s2;
        M_QUAL6: if (strobe && agree_long)  filt <= s2;
        default: filt <= s2;
      endcase
    end
  end

  assign pout = bypass ? raw : filt;

  p_hold_between_strobes_r3: assert property (@(posedge clk) disable iff (rst)
    (!strobe && (mode == M_QUAL3 || mode == M_QUAL6)) |=> $stable(filt));

  p_short_agree_r3: assert property (@(posedge clk) disable iff (rst)
    (!$stable(filt) && $past(mode) == M_QUAL3) |-> (hist[SHORT_N-2:0] == {(SHORT_N-1){filt}}));

  p_long_agree_r4: assert property (@(posedge clk) disable iff (rst)
    (!$stable(filt) && $past(mode) == M_QUAL6) |-> (hist[LONG_N-2:0] == {(LONG_N-1){filt}}));
endmodule

// File: rtl/gpio_qual_bank.sv
module gpio_qual_bank #(
  parameter int NPINS   = 8,
  parameter int PER_W   = 8,
  parameter int DATA_W  = 32,
  parameter int SHORT_N = 3,
  parameter int LONG_N  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              unlock,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [PER_W-1:0]  period,
  input  logic [NPINS-1:0]  pin_periph,
  input  logic [NPINS-1:0]  pin_raw,
  output logic [NPINS-1:0]  pin_out
);
  localparam int SEL_W = 2 * NPINS;

  logic [SEL_W-1:0] sel;
  logic             strobe;

  gqf_sel_reg #(.DATA_W(DATA_W), .NPINS(NPINS)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .unlock(unlock),
    .wr_data(wr_data), .sel(sel), .rd_data(rd_data)
  );

  gqf_strobe #(.PER_W(PER_W)) u_stb (
    .clk(clk), .rst(rst), .period(period), .strobe(strobe)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gqf_pin #(.SHORT_N(SHORT_N), .LONG_N(LONG_N)) u_pin (
      .clk(clk), .rst(rst), .raw(pin_raw[i]), .mode(sel[2*i +: 2]),
      .periph(pin_periph[i]), .strobe(strobe), .pout(pin_out[i])
    );
  end

  p_resv_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && unlock) |=> (rd_data[DATA_W-1:SEL_W] == '0));
endmodule

// File: tb/gpio_qual_bank_test.sv
module gpio_qual_bank_test;
  localparam int N = 8;

  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0, unlock = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [7:0]  period = '0;
  logic [N-1:0] pin_periph = '0, pin_raw = '0, pin_out;

  int checks = 0, fails = 0, cyc = 0;

  gpio_qual_bank uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .unlock(unlock), .wr_data(wr_data),
    .rd_data(rd_data), .period(period), .pin_periph(pin_periph),
    .pin_raw(pin_raw), .pin_out(pin_out)
  );

  always #2 clk = ~clk;

  // Reference state, built from the requirements
  logic [15:0]  m_sel;
  logic [N-1:0] m_s1, m_s2, m_out, m_last;
  int           m_run [N];
  int           m_cnt;

  function automatic bit m_strobe(input logic [7:0] p, input int c);
    return (p == 0) || (c >= 2 * int'(p) - 1);
  endfunction

  function automatic int need(input logic [1:0] md);
    return (md == 2'b01) ? 3 : (md == 2'b10) ? 6 : 0;
  endfunction

  function automatic logic expect_pin(input int i);
    logic [1:0] md = m_sel[2*i +: 2];
    return (md == 2'b11 && pin_periph[i]) ? pin_raw[i] : m_out[i];
  endfunction

  function automatic string tag(input int i);
    logic [1:0] md = m_sel[2*i +: 2];
    if (md == 2'b11) return pin_periph[i] ? "R6" : "R7";
    if (md == 2'b00) return "R2";
    if (period != 0) return "R5";
    return (md == 2'b01) ? "R3" : "R4";
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sel <= '0; m_s1 <= '0; m_s2 <= '0; m_out <= '0; m_last <= '0; m_cnt <= 0;
      for (int i = 0; i < N; i++) m_run[i] <= 6;
    end else begin
      bit st;
      st = m_strobe(period, m_cnt);
      m_cnt <= st ? 0 : m_cnt + 1;
      if (wr_en && unlock) m_sel <= wr_data[15:0];
      m_s1 <= pin_raw;
      m_s2 <= m_s1;
      for (int i = 0; i < N; i++) begin
        int r;
        int k;
        k = need(m_sel[2*i +: 2]);
        r = m_run[i];
        if (st) begin
          r = (m_s2[i] == m_last[i]) ? ((r < 6) ? r + 1 : 6) : 1;
          m_run[i] <= r;
          m_last[i] <= m_s2[i];
        end
        if (k == 0) m_out[i] <= m_s2[i];
        else if (st && r >= k) m_out[i] <= m_s2[i];
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic check_all();
    for (int i = 0; i < N; i++) check(tag(i), 32'(pin_out[i]), 32'(expect_pin(i)));
    check("R10", rd_data, {16'h0, m_sel});
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1", rd_data, 32'h0);
    check("R1", 32'(pin_out), 32'h0);
    rst = 0;

    // R9: reserved half never stored
    @(negedge clk);
    wr_en = 1; unlock = 1; wr_data = 32'hFFFF_5A96;
    @(negedge clk);
    wr_en = 0;
    check("R9", rd_data, 32'h0000_5A96);

    // R8: locked write dropped
    wr_en = 1; unlock = 0; wr_data = 32'h0000_1234;
    @(negedge clk);
    wr_en = 0;
    check("R8", rd_data, 32'h0000_5A96);
    check_all();

    // R6/R7: all pins mode 11, half peripheral
    wr_en = 1; unlock = 1; wr_data = 32'h0000_FFFF; pin_periph = 8'h0F;
    @(negedge clk);
    wr_en = 0;
    pin_raw = 8'hFF;
    #0 check("R6", 32'(pin_out & 8'h0F), 32'h0F);
    check("R7", 32'(pin_out & 8'hF0), 32'h00);
    repeat (3) @(negedge clk);
    check("R7", 32'(pin_out), 32'hFF);
    check_all();

    // Random phase with directed glitches mixed in
    for (int t = 0; t < 6000; t++) begin
      @(negedge clk);
      check_all();
      wr_en = 0;
      if (t % 400 == 0) begin
        period = 8'($urandom % 4);
        pin_periph = 8'($urandom);
      end
      if ($urandom % 25 == 0) begin
        wr_en = 1; unlock = ($urandom % 4) != 0; wr_data = $urandom;
      end
      for (int i = 0; i < N; i++)
        if ($urandom % ((t % 1000 < 500) ? 6 : 20) == 0) pin_raw[i] = ~pin_raw[i];
    end
    @(negedge clk);
    check_all();
    finish_run();
  end
endmodule